// File: doc/BRIEF.md
# Pulse-Gated Reference Cycle Counter

This block measures a reference clock against a once-per-second timing pulse. It counts reference cycles across a gate of one, two hundred or one thousand pulse intervals and reports the whole count together with its signed deviation from the nominal value. The block runs in the reference clock domain. The raw pulse passes through a flop synchronizer and a rising-edge detector. One detected edge opens a gate and a later detected edge closes it. Both events take the same path, so the synchronizer delay drops out of the result. The edge that closes one gate opens the next one at once, which gives a continuous series of measurements for a disciplining loop to use.

The result interface is valid-only and takes no back-pressure. When a gate completes, `cnt_valid` is high for exactly one clock. `cnt_value`, `cnt_error`, `locked` and `miscount` update in that cycle and keep their values until the next result, so a consumer may sample them at any later time. Three plain status outputs sit beside the result. A lock flag has hysteresis. An activity output toggles on every detected pulse. An alarm reports a missing pulse and cancels the gate that is in progress.

Top module: `ppsc_counter`

## Requirements
- R1: `pps_in` passes through two synchronizing flops and a rising-edge detector, and both opening and closing use that detected edge. The reported count is the number of clock cycles from the opening edge to the closing edge, which equals the sum of the raw pulse intervals inside the gate.
- R2: `gate_sel` chooses the gate length in pulse intervals: 0 gives GATE_SHORT, 1 gives GATE_MID, and 2 or 3 give GATE_LONG. The value is captured when a gate opens, so a change in the middle of a gate applies only to the following gate.
- R3: A closing edge opens the next gate in the same cycle, and no reference cycle is lost between two gates.
- R4: `cnt_valid` is high for one clock per completed gate. `cnt_value` and `cnt_error` change only in that cycle.
- R5: `cnt_error` is `cnt_value` minus CYCLES_PER_SEC times the gate length. It is computed over the full CNT_W-bit width and given as a two's-complement value.
- R6: `locked` sets on a result whose error is exactly zero. It stays set while each following result has an error of -1, 0 or +1. It clears on any result outside that range and stays clear until a result with zero error arrives.
- R7: `miscount` updates with each result. It is 1 only when the result came from a GATE_LONG gate (select 2 or 3) and the error magnitude is at least MISCOUNT.
- R8: `activity` toggles once on every detected pulse edge.
- R9: `pulse_missing` goes high once 2×CYCLES_PER_SEC cycles have passed since the last detected edge (or since reset) without a new edge. It stays high until the next edge. An interval one cycle shorter than that does not raise it.
- R10: A missing pulse cancels the gate in progress, and no `cnt_valid` is given for it. The next detected edge opens a new gate using the current `gate_sel`.
- R11: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| pps_in | input | 1 | Raw pulse, asynchronous |
| gate_sel | input | 2 | Gate length select |
| cnt_valid | output | 1 | One-clock result strobe |
| cnt_value | output | CNT_W | Cycles counted in the last gate |
| cnt_error | output | CNT_W | Signed count minus expected count |
| locked | output | 1 | Lock flag with hysteresis |
| activity | output | 1 | Toggles on each pulse |
| pulse_missing | output | 1 | Missing-pulse alarm |
| miscount | output | 1 | Large error on a long gate |

## Verification
A pulse that arrives in the very cycle the watchdog expires triggers two things at once: the edge that would close the gate and the alarm that cancels it. Pulse spacing is set to exactly twice the cycles-per-second value to cause this. The outcome is judged by seeing no result strobes while the alarm still pulses. Spacing one cycle shorter must give a normal result and no alarm. In the same spirit, a change of the gate select lands on a gate that is already running, and the bench checks that this gate keeps its old length while the next one takes the new length.

// File: rtl/ppsc_pkg.sv
package ppsc_pkg;
  typedef enum logic [1:0] {
    GSEL_SHORT    = 2'd0,
    GSEL_MID      = 2'd1,
    GSEL_LONG     = 2'd2,
    GSEL_LONG_ALT = 2'd3
  } gsel_e;

  function automatic logic is_long(input logic [1:0] sel);
    return sel[1];
  endfunction
endpackage

// File: rtl/ppsc_edge_sync.sv
module ppsc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ppsc_watchdog.sv
module ppsc_watchdog #(
  parameter longint unsigned LIMIT = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic missing
);
  localparam int WW = $clog2(LIMIT + 1);
  localparam logic [WW-1:0] LAST = WW'(LIMIT - 1);

  logic [WW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)            since <= '0;
    else if (rise)         since <= '0;
    else if (since != LAST) since <= since + 1'b1;
  end

  assign missing = (since == LAST);
endmodule

// File: rtl/ppsc_gate.sv
module ppsc_gate #(
  parameter int CNT_W   = 34,
  parameter int G_SHORT = 1,
  parameter int G_MID   = 200,
  parameter int G_LONG  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             missing,
  input  logic [1:0]       sel,
  output logic             res_valid,
  output logic [CNT_W-1:0] res,
  output logic [1:0]       res_sel
);
  localparam int EDGE_W = $clog2(G_LONG + 1);

  function automatic logic [EDGE_W-1:0] edges_for(input logic [1:0] s);
    case (s)
      ppsc_pkg::GSEL_SHORT: return EDGE_W'(G_SHORT);
      ppsc_pkg::GSEL_MID:   return EDGE_W'(G_MID);
      default:              return EDGE_W'(G_LONG);
    endcase
  endfunction

  logic              running;
  logic [EDGE_W-1:0] left;
  logic [1:0]        cur_sel;
  logic [CNT_W-1:0]  acc;
  logic              last_edge, close_g, open_g;

  assign last_edge = (left == EDGE_W'(1));
  assign close_g   = rise && running && !missing && last_edge;
  assign open_g    = rise && (!running || missing || last_edge);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      left      <= '0;
      cur_sel   <= '0;
      acc       <= '0;
      res_valid <= 1'b0;
      res       <= '0;
      res_sel   <= '0;
    end else begin
      res_valid <= close_g;
      if (close_g) begin
        res     <= acc;
        res_sel <= cur_sel;
      end
      if (open_g) begin
        running <= 1'b1;
        acc     <= CNT_W'(1);
        left    <= edges_for(sel);
        cur_sel <= sel;
      end else if (missing) begin
        running <= 1'b0;
      end else if (running) begin
        acc <= acc + 1'b1;
        if (rise) left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ppsc_judge.sv
module ppsc_judge #(
  parameter int              CNT_W    = 34,
  parameter longint unsigned CPS      = 10_000_000,
  parameter int              G_SHORT  = 1,
  parameter int              G_MID    = 200,
  parameter int              G_LONG   = 1000,
  parameter int              MISCOUNT = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [CNT_W-1:0] res,
  input  logic [1:0]       res_sel,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] err_o,
  output logic             locked,
  output logic             miscount
);
  localparam logic [CNT_W-1:0] EXP_S = CNT_W'(CPS * longint'(G_SHORT));
  localparam logic [CNT_W-1:0] EXP_M = CNT_W'(CPS * longint'(G_MID));
  localparam logic [CNT_W-1:0] EXP_L = CNT_W'(CPS * longint'(G_LONG));

  logic [CNT_W-1:0] expv, diff, mag;
  logic             hit, near, big;

  always_comb begin
    case (res_sel)
      ppsc_pkg::GSEL_SHORT: expv = EXP_S;
      ppsc_pkg::GSEL_MID:   expv = EXP_M;
      default:              expv = EXP_L;
    endcase
    diff = res - expv;
    mag  = diff[CNT_W-1] ? (~diff + 1'b1) : diff;
    hit  = (diff == '0);
    near = (mag <= CNT_W'(1));
    big  = ppsc_pkg::is_long(res_sel) && (mag >= CNT_W'(MISCOUNT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      count_o  <= '0;
      err_o    <= '0;
      locked   <= 1'b0;
      miscount <= 1'b0;
    end else begin
      valid_o <= res_valid;
      if (res_valid) begin
        count_o  <= res;
        err_o    <= diff;
        miscount <= big;
        locked   <= hit || (locked && near);
      end
    end
  end
endmodule

// File: rtl/ppsc_counter.sv
module ppsc_counter #(
  parameter longint unsigned CYCLES_PER_SEC = 10_000_000,
  parameter int              GATE_SHORT     = 1,
  parameter int              GATE_MID       = 200,
  parameter int              GATE_LONG      = 1000,
  parameter int              CNT_W          = 34,
  parameter int              MISCOUNT       = 50,
  parameter int              SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_in,
  input  logic [1:0]       gate_sel,
  output logic             cnt_valid,
  output logic [CNT_W-1:0] cnt_value,
  output logic [CNT_W-1:0] cnt_error,
  output logic             locked,
  output logic             activity,
  output logic             pulse_missing,
  output logic             miscount
);
  localparam longint unsigned WD_LIMIT = 2 * CYCLES_PER_SEC;

  logic             edge_rise;
  logic             g_valid;
  logic [CNT_W-1:0] g_res;
  logic [1:0]       g_sel;

  ppsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pps_in), .rise(edge_rise)
  );

  ppsc_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst_n(rst_n), .rise(edge_rise), .missing(pulse_missing)
  );

  ppsc_gate #(
    .CNT_W(CNT_W), .G_SHORT(GATE_SHORT), .G_MID(GATE_MID), .G_LONG(GATE_LONG)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .rise(edge_rise), .missing(pulse_missing),
    .sel(gate_sel), .res_valid(g_valid), .res(g_res), .res_sel(g_sel)
  );

  ppsc_judge #(
    .CNT_W(CNT_W), .CPS(CYCLES_PER_SEC), .G_SHORT(GATE_SHORT),
    .G_MID(GATE_MID), .G_LONG(GATE_LONG), .MISCOUNT(MISCOUNT)
  ) u_judge (
    .clk(clk), .rst_n(rst_n), .res_valid(g_valid), .res(g_res), .res_sel(g_sel),
    .valid_o(cnt_valid), .count_o(cnt_value), .err_o(cnt_error),
    .locked(locked), .miscount(miscount)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         activity <= 1'b0;
    else if (edge_rise) activity <= ~activity;
  end
endmodule

// File: rtl/ppsc_counter_sva.sv
module ppsc_counter_sva #(
  parameter int CNT_W = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             cnt_valid,
  input logic [CNT_W-1:0] cnt_value,
  input logic [CNT_W-1:0] cnt_error,
  input logic             locked,
  input logic             activity,
  input logic             pulse_missing,
  input logic             miscount
);
  logic err_in_window;
  assign err_in_window = (cnt_error == '0) || (cnt_error == CNT_W'(1)) || (cnt_error == '1);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |=> !cnt_valid); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_valid |-> ($stable(cnt_value) && $stable(cnt_error))); // R4
  AST_LOCK_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (cnt_valid && cnt_error == '0)); // R6
  AST_LOCK_DROP_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_valid && !err_in_window) |-> !locked); // R6
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_valid |-> $stable(locked)); // R6
  AST_MISCOUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_valid |-> $stable(miscount)); // R7
  AST_ACT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (activity != $past(activity)) |-> $past(rise)); // R8
  AST_ALARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !pulse_missing); // R9
  AST_ABORT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_missing |=> ##1 !cnt_valid); // R10
endmodule

bind ppsc_counter ppsc_counter_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .rise(edge_rise), .cnt_valid(cnt_valid),
  .cnt_value(cnt_value), .cnt_error(cnt_error), .locked(locked),
  .activity(activity), .pulse_missing(pulse_missing), .miscount(miscount)
);

// File: tb/tb_ppsc_counter.sv
module tb_ppsc_counter;
  localparam longint CPS = 40;
  localparam int GS = 1, GM = 3, GL = 5, W = 34, MISC = 50;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, pps_in = 1'b0;
  logic [1:0] gate_sel = 2'd0;
  logic cnt_valid, locked, activity, pulse_missing, miscount;
  logic [W-1:0] cnt_value, cnt_error;

  ppsc_counter #(
    .CYCLES_PER_SEC(CPS), .GATE_SHORT(GS), .GATE_MID(GM), .GATE_LONG(GL),
    .CNT_W(W), .MISCOUNT(MISC), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .gate_sel(gate_sel),
    .cnt_valid(cnt_valid), .cnt_value(cnt_value), .cnt_error(cnt_error),
    .locked(locked), .activity(activity), .pulse_missing(pulse_missing),
    .miscount(miscount)
  );

  int checks = 0, errors = 0;
  int period = 40;
  bit gen_en = 1'b0;
  bit alarm_seen = 1'b0;
  int valid_seen = 0;

  typedef struct packed {
    logic [1:0]         sel;
    logic [15:0]        per;
    logic signed [15:0] err2;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'd41,  16'sd1},  '{2'd0, 16'd40, 16'sd0},  '{2'd1, 16'd40,  16'sd0},
    '{2'd1, 16'd41,  16'sd3},  '{2'd2, 16'd40, 16'sd0},  '{2'd2, 16'd50,  16'sd50},
    '{2'd2, 16'd30, -16'sd50}, '{2'd3, 16'd40, 16'sd0},  '{2'd0, 16'd39, -16'sd1},
    '{2'd0, 16'd40,  16'sd0},  '{2'd0, 16'd39, -16'sd1}, '{2'd1, 16'd41,  16'sd3},
    '{2'd1, 16'd60,  16'sd60}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int n_of(input logic [1:0] s);
    return (s == 2'd0) ? GS : (s == 2'd1) ? GM : GL;
  endfunction

  // pulse generator: raw rising edges exactly 'period' cycles apart
  initial begin
    forever begin
      wait (gen_en);
      begin
        int cur;
        cur = period;
        pps_in = 1'b1;
        repeat (2) @(negedge clk);
        pps_in = 1'b0;
        repeat (cur - 2) @(negedge clk);
      end
    end
  end

  always @(negedge clk) begin
    if (pulse_missing) alarm_seen = 1'b1;
    if (cnt_valid) valid_seen++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wait_result();
    do @(negedge clk); while (!cnt_valid);
  endtask

  bit lock_m = 1'b0;
  bit act_m  = 1'b0;

  task automatic judge(input longint exp_cnt, input logic [1:0] s, input string tag);
    longint exp_err, got_err, mag;
    bit mis_m;
    exp_err = exp_cnt - CPS * n_of(s);
    mag = (exp_err < 0) ? -exp_err : exp_err;
    if (exp_err == 0) lock_m = 1'b1;
    else if (mag > 1) lock_m = 1'b0;
    mis_m = (s >= 2'd2) && (mag >= MISC);
    act_m = act_m ^ n_of(s)[0];
    got_err = longint'($signed(cnt_error));
    chk(cnt_value == W'(exp_cnt), {tag, " R1 count"}, longint'(cnt_value), exp_cnt);
    chk(got_err == exp_err, {tag, " R5 error"}, got_err, exp_err);
    chk(locked == lock_m, {tag, " R6 lock"}, longint'(locked), longint'(lock_m));
    chk(miscount == mis_m, {tag, " R7 miscount"}, longint'(miscount), longint'(mis_m));
    chk(activity == act_m, {tag, " R8 activity"}, longint'(activity), longint'(act_m));
  endtask

  initial begin
    int prev_p, prev_n;
    logic [1:0] prev_s;
    // R11: reset state
    gate_sel = VECS[0].sel;
    period = int'(VECS[0].per);
    repeat (3) @(negedge clk);
    chk(!cnt_valid && cnt_value == '0 && cnt_error == '0, "R11 result outputs", longint'(cnt_value), 0);
    chk(!locked && !activity && !pulse_missing && !miscount, "R11 flags",
        longint'({locked, activity, pulse_missing, miscount}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    gen_en = 1'b1;
    act_m = 1'b1;  // the opening edge of the very first gate toggles once
    prev_p = int'(VECS[0].per);
    prev_n = n_of(VECS[0].sel);
    prev_s = VECS[0].sel;

    for (int i = 0; i < NV; i++) begin
      gate_sel = VECS[i].sel;
      period = int'(VECS[i].per);
      // first result: gate opened before the change, old select, first interval old period (R2, R3)
      wait_result();
      judge(longint'(prev_p) + longint'(prev_n - 1) * longint'(VECS[i].per), prev_s,
            $sformatf("vec%0d first R2 R3", i));
      // second result: fully under the new settings
      wait_result();
      judge(longint'(n_of(VECS[i].sel)) * longint'(VECS[i].per), VECS[i].sel,
            $sformatf("vec%0d second", i));
      chk(longint'($signed(cnt_error)) == longint'(VECS[i].err2), "R5 table error",
          longint'($signed(cnt_error)), longint'(VECS[i].err2));
      prev_p = int'(VECS[i].per);
      prev_n = n_of(VECS[i].sel);
      prev_s = VECS[i].sel;
    end

    // R4: strobe lasts one clock
    @(negedge clk);
    chk(!cnt_valid, "R4 strobe width", longint'(cnt_valid), 0);

    // R9 boundary: interval one short of the watchdog limit gives results and no alarm
    gate_sel = 2'd0;
    period = 79;
    wait_result();
    @(posedge clk);
    alarm_seen = 1'b0;
    wait_result();
    chk(cnt_value == W'(79), "R9 short-of-limit count", longint'(cnt_value), 79);
    wait_result();
    chk(!alarm_seen, "R9 no alarm at limit-1", longint'(alarm_seen), 0);

    // R9/R10 coincidence: edge lands in the expiry cycle
    period = 80;
    repeat (200) @(negedge clk);
    @(posedge clk);
    alarm_seen = 1'b0;
    valid_seen = 0;
    repeat (400) @(negedge clk);
    chk(valid_seen == 0, "R10 no result when edge meets expiry", valid_seen, 0);
    chk(alarm_seen, "R9 alarm at exact limit", longint'(alarm_seen), 1);

    // R10 recovery with a long gate
    gate_sel = 2'd2;
    period = 40;
    wait_result();
    wait_result();
    chk(cnt_value == W'(200), "R10 recovery count", longint'(cnt_value), 200);

    // R10: pulses stop mid-gate
    gen_en = 1'b0;
    repeat (60) @(negedge clk);
    @(posedge clk);
    valid_seen = 0;
    repeat (300) @(negedge clk);
    chk(valid_seen == 0, "R10 aborted gate gives no strobe", valid_seen, 0);
    chk(pulse_missing, "R9 alarm held", longint'(pulse_missing), 1);
    gen_en = 1'b1;
    repeat (6) @(negedge clk);
    chk(!pulse_missing, "R9 alarm cleared by edge", longint'(pulse_missing), 0);
    wait_result();
    chk(cnt_value == W'(200) && cnt_error == '0, "R10 fresh gate after abort",
        longint'(cnt_value), 200);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule